// File: doc/BRIEF.md
# Card Presence Debounce and Host Interrupt

This block watches a smart-card connector's presence switch, together with a supply undervoltage flag and a combined fault flag, and drives one active-low interrupt line toward the host. Either a normally-open switch (wired to an active-low pin) or a normally-closed switch (wired to an active-high pin) can be used. The pin that is not used is tied to its absent level. Both pins pass through a synchronizer first. An insertion is reported only after the presence level has stayed steady for a programmable number of clock cycles. A removal is reported as soon as the synchronized level drops.

While no session is open, the interrupt level shows whether a card is present. While the host holds its active-low session command low, a fault, an undervoltage, or a card removal latches a deactivation request toward the activation sequencer and pulls the interrupt low. The latch holds until the host has released the command and the sequencer reports that deactivation is done. The undervoltage, fault and done inputs are already synchronous to the clock. Comparators, thresholds and power-on reset generation happen upstream of this block.

Top module: `card_presence_irq`

## Requirements
- R1: A card counts as present when `pres_n_i` is 0 or `pres_i` is 1. With both pins at their absent levels (`pres_n_i`=1, `pres_i`=0), no card is present.
- R2: After reset, `irq_n_o` is 0 and `deact_req_o` is 0.
- R3: When a presence pin becomes active and stays active, `irq_n_o` stays 0 through the first 1+DEBOUNCE_CYCLES rising edges and becomes 1 after edge 2+DEBOUNCE_CYCLES (two synchronizer stages plus the debounce count).
- R4: If the synchronized presence level returns to absent before the debounce completes, the count restarts. A new insertion then again needs the full 2+DEBOUNCE_CYCLES edges.
- R5: On card removal, `irq_n_o` goes to 0 two rising edges after the pin change, with no debounce.
- R6: While `cmd_n_i`=1 and no request is latched, `irq_n_o` is 1 exactly when a debounced card is present and `uvlo_i` is 0.
- R7: While `uvlo_i`=1, `irq_n_o` is 0 in that same cycle. When `uvlo_i` returns to 0 with a card still present, `irq_n_o` returns to 1.
- R8: While `cmd_n_i`=0, any of `fault_i`=1, `uvlo_i`=1 or a missing card sets `deact_req_o` to 1 at the next rising edge. While the request is set, `irq_n_o` is 0.
- R9: Once set, `deact_req_o` holds until a rising edge at which both `cmd_n_i`=1 and `deact_done_i`=1. After that, `irq_n_o` again follows card presence.
- R10: `deact_done_i` has no effect while `cmd_n_i`=0.
- R11: While `cmd_n_i`=1, `fault_i` has no effect. It sets no request and does not lower `irq_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pres_n_i | input | 1 | Presence switch, low means card present (normally-open connector) |
| pres_i | input | 1 | Presence switch, high means card present (normally-closed connector) |
| uvlo_i | input | 1 | Host-side supply below its threshold (synchronous flag) |
| fault_i | input | 1 | Card-supply overload, overtemperature or supply drop (synchronous flag) |
| cmd_n_i | input | 1 | Host session command, low while a session is open |
| deact_done_i | input | 1 | Sequencer has finished deactivation |
| irq_n_o | output | 1 | Host interrupt, active low |
| deact_req_o | output | 1 | Latched deactivation request to the sequencer |

## Verification
Two coincidences matter here. The first is the debounce count expiring in the same cycle that undervoltage is asserted. The bench holds `uvlo_i` high across the expected expiry edge. It checks that the interrupt stays low on that edge and rises only once the flag drops. The second is a fault and a card removal arriving together during a session. The bench drives both in one cycle. It checks that a single request appears one edge later, that the interrupt is low, and that after the release handshake the interrupt shows the card as absent.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned PIN_COUNT   = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/cpi_sync.sv
module cpi_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cpi_debounce.sv
module cpi_debounce #(
  parameter int unsigned CYCLES = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic card_o
);
  localparam int unsigned CW = cpi_pkg::cnt_width(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          card_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      card_q <= 1'b0;
    end else if (!raw_i) begin
      cnt_q  <= '0;   // bounce or removal restarts
      card_q <= 1'b0;
    end else if (!card_q) begin
      if (cnt_q == LAST) begin
        card_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // removal acts without waiting for the register
  assign card_o = card_q & raw_i;
endmodule

// File: rtl/cpi_fault_latch.sv
module cpi_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_n_i,
  input  logic card_i,
  input  logic uvlo_i,
  input  logic fault_i,
  input  logic done_i,
  output logic req_o
);
  logic req_q;
  logic trip;

  assign trip = !cmd_n_i && (fault_i || uvlo_i || !card_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                req_q <= 1'b0;
    else if (trip)              req_q <= 1'b1;
    else if (cmd_n_i && done_i) req_q <= 1'b0;
  end

  assign req_o = req_q;
endmodule

// File: rtl/card_presence_irq.sv
module card_presence_irq #(
  parameter int unsigned DEBOUNCE_CYCLES = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pres_n_i,
  input  logic pres_i,
  input  logic uvlo_i,
  input  logic fault_i,
  input  logic cmd_n_i,
  input  logic deact_done_i,
  output logic irq_n_o,
  output logic deact_req_o
);
  import cpi_pkg::*;

  logic [PIN_COUNT-1:0] pin_act;
  logic [PIN_COUNT-1:0] pin_sync;
  logic                 present_sync;
  logic                 card;
  logic                 req;

  assign pin_act = {~pres_n_i, pres_i};

  cpi_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_act),
    .q_o   (pin_sync)
  );

  assign present_sync = |pin_sync;

  cpi_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (present_sync),
    .card_o(card)
  );

  cpi_fault_latch u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_n_i(cmd_n_i),
    .card_i (card),
    .uvlo_i (uvlo_i),
    .fault_i(fault_i),
    .done_i (deact_done_i),
    .req_o  (req)
  );

  assign deact_req_o = req;
  assign irq_n_o     = card & ~uvlo_i & ~req;
endmodule

// File: rtl/card_presence_irq_chk.sv
module card_presence_irq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic uvlo_i,
  input logic fault_i,
  input logic cmd_n_i,
  input logic deact_done_i,
  input logic present_sync,
  input logic irq_n_o,
  input logic deact_req_o
);
  assert_uvlo_masks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> !irq_n_o);
  assert_absent_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_sync |-> !irq_n_o);
  assert_req_masks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_req_o |-> !irq_n_o);
  assert_fault_trips_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_n_i && fault_i) |=> deact_req_o);
  assert_hold_session_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deact_req_o && !cmd_n_i) |=> deact_req_o);
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deact_req_o && cmd_n_i && deact_done_i) |=> !deact_req_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!deact_req_o && cmd_n_i) |=> !deact_req_o);
endmodule

bind card_presence_irq card_presence_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .uvlo_i      (uvlo_i),
  .fault_i     (fault_i),
  .cmd_n_i     (cmd_n_i),
  .deact_done_i(deact_done_i),
  .present_sync(present_sync),
  .irq_n_o     (irq_n_o),
  .deact_req_o (deact_req_o)
);

// File: tb/card_presence_irq_bench.sv
module card_presence_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEB        = 16;
  localparam int INS_EDGES  = DEB + 2;

  typedef struct packed {
    logic pres_n, pres, uvlo, fault, cmd_n, done;
    int   waits;
    logic exp_irq, exp_req;
    int   tag;
  } vec_t;

  // pres_n pres uvlo fault cmd_n done waits irq req tag
  localparam vec_t VEC [15] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,20,1'b1,1'b0,6},  // R6 insert, idle
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 1,1'b0,1'b0,7},  // R7
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1,1'b1,1'b0,7},  // R7 recovers
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 2,1'b1,1'b0,11}, // R11
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2,1'b1,1'b0,8},  // R8 clean session
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1,1'b0,1'b1,8},  // R8 fault
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2,1'b0,1'b1,9},  // R9 held
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2,1'b0,1'b1,10}, // R10
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2,1'b0,1'b1,9},  // R9 waits done
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1,1'b1,1'b0,9},  // R9 release
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 2,1'b0,1'b0,5},  // R5
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,20,1'b1,1'b0,1},  // R1 high pin
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2,1'b1,1'b0,8},  // R8
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 3,1'b0,1'b1,8},  // R8 removal
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 1,1'b0,1'b0,9}   // R9 then absent
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pres_n_i = 1'b1, pres_i = 1'b0, uvlo_i = 1'b0, fault_i = 1'b0;
  logic cmd_n_i = 1'b1, deact_done_i = 1'b0;
  logic irq_n_o, deact_req_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  card_presence_irq #(.DEBOUNCE_CYCLES(DEB)) u_card_presence_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pres_n_i(pres_n_i), .pres_i(pres_i),
    .uvlo_i(uvlo_i), .fault_i(fault_i), .cmd_n_i(cmd_n_i),
    .deact_done_i(deact_done_i), .irq_n_o(irq_n_o), .deact_req_o(deact_req_o)
  );

  task automatic check(input int tag, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; pres_n_i = 1'b1; pres_i = 1'b0; uvlo_i = 1'b0;
    fault_i = 1'b0; cmd_n_i = 1'b1; deact_done_i = 1'b0;
    edges(2);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check(2, irq_n_o, 1'b0, "R2 irq after reset");
    check(2, deact_req_o, 1'b0, "R2 req after reset");

    foreach (VEC[k]) begin
      pres_n_i = VEC[k].pres_n; pres_i = VEC[k].pres; uvlo_i = VEC[k].uvlo;
      fault_i = VEC[k].fault; cmd_n_i = VEC[k].cmd_n; deact_done_i = VEC[k].done;
      edges(VEC[k].waits);
      check(VEC[k].tag, irq_n_o, VEC[k].exp_irq, $sformatf("row %0d irq", k));
      check(VEC[k].tag, deact_req_o, VEC[k].exp_req, $sformatf("row %0d req", k));
    end

    // R3 exact insertion latency
    do_reset();
    pres_n_i = 1'b0;
    edges(INS_EDGES - 1);
    check(3, irq_n_o, 1'b0, "R3 one edge before expiry");
    edges(1);
    check(3, irq_n_o, 1'b1, "R3 at expiry");

    // R4 bounce restarts the count
    do_reset();
    pres_i = 1'b1;
    edges(10);
    pres_i = 1'b0;
    edges(3);
    pres_i = 1'b1;
    edges(INS_EDGES - 1);
    check(4, irq_n_o, 1'b0, "R4 restarted count not done");
    edges(1);
    check(4, irq_n_o, 1'b1, "R4 restarted count done");

    // R7 with R3: undervoltage across debounce expiry
    do_reset();
    pres_n_i = 1'b0;
    edges(INS_EDGES - 2);
    uvlo_i = 1'b1;
    edges(2);
    check(7, irq_n_o, 1'b0, "R7 uvlo at expiry");
    uvlo_i = 1'b0;
    #1;
    check(3, irq_n_o, 1'b1, "R3 presence after uvlo drop");

    // R8 fault and removal in the same cycle
    @(negedge clk_i);
    cmd_n_i = 1'b0;
    edges(2);
    check(8, deact_req_o, 1'b0, "R8 session clean");
    fault_i = 1'b1; pres_n_i = 1'b1;
    edges(1);
    check(8, deact_req_o, 1'b1, "R8 coincident trip");
    check(8, irq_n_o, 1'b0, "R8 irq coincident");
    fault_i = 1'b0; cmd_n_i = 1'b1; deact_done_i = 1'b1;
    edges(1);
    check(9, deact_req_o, 1'b0, "R9 release");
    check(9, irq_n_o, 1'b0, "R9 shows absent");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule